// File: doc/BRIEF.md
# Prescaled Fan PWM Generator

This block drives a fan's speed-control pin with a pulse-width-modulated waveform. The time base comes from one of two single-cycle tick enables, both running in the system clock domain. The select bit in the prescale register chooses between a fast tick (nominally 3 MHz) and a slow tick (nominally 125 kHz). A 7-bit divider slows the chosen tick by the register field plus one. Each divided step advances an 8-bit counter, so one PWM period lasts 256 steps. The output is high for as many of those steps as the duty value asks for.

Software reaches three byte-wide registers through a synchronous port with a one-cycle write strobe and combinational read data. The registers hold the prescale and clock select, the manual duty, and the control type. When the control type is not manual, the generator uses a duty value supplied on a bypass input by an external controller, and reads of the duty address return that value. New settings are taken up only when the counter wraps, so a period that is already running is never cut short.

Top module: `fanpwm_top`

## Requirements
- R1: After reset, the prescale register reads 01h (fast tick, divide by 2), the duty register reads FFh and the configuration register reads 00h.
- R2: Address 0 holds the prescale register, address 1 the duty register and address 2 the configuration register. A write with the strobe high is visible on a read in the following cycle. Only bits 5:4 of the configuration register are stored, and its other bits read as 0. Address 3 reads as 00h.
- R3: For a duty value N from 01h to FEh, the output is high for N steps and low for the remaining 256-N steps of each 256-step period, and the high part starts at the period boundary.
- R4: Duty 00h keeps the output low at all times. Duty FFh keeps it high at all times, with no low step.
- R5: Prescale bits 6:0 hold a value M. One counter step then takes M+1 selected ticks, so a period lasts 256*(M+1) selected ticks.
- R6: When prescale bit 7 is 0 the fast tick input paces the divider. When it is 1 the slow tick input paces it, and the other tick input has no effect.
- R7: Changes to the duty, prescale, mode or bypass value reach the output only at the period boundary, which is the step on which the counter wraps from 255 to 0. A write landing in the same cycle as that wrap takes effect at the following boundary.
- R8: When configuration bits 5:4 are not 00 (01 thermal cruise, 10 speed cruise, 11 reserved), the generator loads the bypass duty input at each boundary, and reads of address 1 return that input. The written duty value is kept and used again once bits 5:4 return to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast_i | input | 1 | Single-cycle enable of the fast time base |
| tick_slow_i | input | 1 | Single-cycle enable of the slow time base |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| auto_duty_i | input | 8 | Duty value from an external automatic controller |
| pwm_o | output | 1 | Fan PWM output |

## Verification
Two functions can fall in the same cycle: a software write to the duty register, and the counter wrap that copies the duty into the working compare register. The bench locks onto a rising edge of the output with the divider set to one, counts forward to the exact wrap cycle, and holds the write strobe through that cycle. The following period must still show the old high count, the one after it the new count, and read-back must show the new value at once.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

    localparam int DUTY_W   = 8;
    localparam int PRE_W    = 7;
    localparam int ADDR_W   = 2;
    localparam int MODE_LSB = 4;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        CTL_MANUAL  = 2'b00,
        CTL_THERMAL = 2'b01,
        CTL_SPEED   = 2'b10,
        CTL_RSVD    = 2'b11
    } ctl_mode_e;

    typedef struct packed {
        logic             slow_sel;
        logic [PRE_W-1:0] div_m1;
    } pre_cfg_t;

    localparam logic [ADDR_W-1:0] ADR_PRE  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DUTY = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CFG  = 2'd2;

    localparam pre_cfg_t           PRE_RST  = '{slow_sel: 1'b0, div_m1: 7'd1};
    localparam logic [DUTY_W-1:0]  DUTY_RST = '1;

    function automatic logic is_auto(ctl_mode_e m);
        return m != CTL_MANUAL;
    endfunction

    function automatic logic [DUTY_W-1:0] cfg_to_byte(ctl_mode_e m);
        logic [DUTY_W-1:0] b;
        b = '0;
        b[MODE_LSB +: MODE_W] = m;
        return b;
    endfunction

endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DUTY_W-1:0] wdata_i,
    input  logic [DUTY_W-1:0] auto_duty_i,
    output pre_cfg_t          pre_cfg_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic [DUTY_W-1:0] rdata_o
);

    pre_cfg_t          pre_q;
    logic [DUTY_W-1:0] duty_q;
    ctl_mode_e         mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= PRE_RST;
            duty_q <= DUTY_RST;
            mode_q <= CTL_MANUAL;
        end else if (wr_en_i) begin
            case (addr_i)
                ADR_PRE:  pre_q  <= pre_cfg_t'(wdata_i);
                ADR_DUTY: duty_q <= wdata_i;
                ADR_CFG:  mode_q <= ctl_mode_e'(wdata_i[MODE_LSB +: MODE_W]);
                default:  ;
            endcase
        end
    end

    assign duty_o    = is_auto(mode_q) ? auto_duty_i : duty_q;
    assign pre_cfg_o = pre_q;

    always_comb begin
        case (addr_i)
            ADR_PRE:  rdata_o = pre_q;
            ADR_DUTY: rdata_o = duty_o;
            ADR_CFG:  rdata_o = cfg_to_byte(mode_q);
            default:  rdata_o = '0;
        endcase
    end

    assert_cfg_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_i == ADR_CFG) |-> ((rdata_o & 8'hCF) == 8'h00));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADR_DUTY) |=> (duty_q == $past(wdata_i)));

    assert_auto_read_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q != CTL_MANUAL && addr_i == ADR_DUTY) |-> (rdata_o == auto_duty_i));

endmodule

// File: rtl/fanpwm_prescaler.sv
module fanpwm_prescaler
    import fanpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_fast_i,
    input  logic     tick_slow_i,
    input  pre_cfg_t cfg_i,
    input  logic     load_i,
    output logic     step_o
);

    pre_cfg_t         cfg_act;
    logic [PRE_W-1:0] div_cnt;
    logic             tick;
    logic             last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= PRE_RST;
        end else if (load_i) begin
            cfg_act <= cfg_i;
        end
    end

    assign tick   = cfg_act.slow_sel ? tick_slow_i : tick_fast_i;
    assign last   = (div_cnt == cfg_act.div_m1);
    assign step_o = tick && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= last ? '0 : div_cnt + 1'b1;
        end
    end

    assert_div_bound_R5: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= cfg_act.div_m1);

    assert_slow_source_R6: assert property (@(posedge clk) disable iff (rst)
        (step_o && cfg_act.slow_sel) |-> tick_slow_i);

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cfg_act));

endmodule

// File: rtl/fanpwm_wave.sv
module fanpwm_wave
    import fanpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              load_o,
    output logic              pwm_o
);

    localparam logic [DUTY_W-1:0] CNT_MAX = '1;

    logic [DUTY_W-1:0] cnt;
    logic [DUTY_W-1:0] duty_act;

    assign load_o = step_i && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            duty_act <= DUTY_RST;
        end else begin
            if (step_i) begin
                cnt <= cnt + 1'b1;
            end
            if (load_o) begin
                duty_act <= duty_i;
            end
        end
    end

    assign pwm_o = (duty_act == CNT_MAX) || (cnt < duty_act);

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(cnt));

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load_o |=> $stable(duty_act));

endmodule

// File: rtl/fanpwm_top.sv
module fanpwm_top
    import fanpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_fast_i,
    input  logic              tick_slow_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DUTY_W-1:0] wdata_i,
    output logic [DUTY_W-1:0] rdata_o,
    input  logic [DUTY_W-1:0] auto_duty_i,
    output logic              pwm_o
);

    pre_cfg_t          pre_cfg;
    logic [DUTY_W-1:0] duty_eff;
    logic              step;
    logic              wrap;

    fanpwm_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .auto_duty_i (auto_duty_i),
        .pre_cfg_o   (pre_cfg),
        .duty_o      (duty_eff),
        .rdata_o     (rdata_o)
    );

    fanpwm_prescaler u_pre (
        .clk         (clk),
        .rst         (rst),
        .tick_fast_i (tick_fast_i),
        .tick_slow_i (tick_slow_i),
        .cfg_i       (pre_cfg),
        .load_i      (wrap),
        .step_o      (step)
    );

    fanpwm_wave u_wave (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .duty_i (duty_eff),
        .load_o (wrap),
        .pwm_o  (pwm_o)
    );

endmodule

// File: tb/fanpwm_top_tb.sv
module fanpwm_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_fast;
    logic       tick_slow;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [7:0] auto_duty;
    logic       pwm;

    int checks = 0;
    int errors = 0;
    int fast_sp = 1;
    int slow_sp = 4;
    int tk = 0;
    bit done = 1'b0;

    localparam int LIM = 20000;

    always #10 clk = ~clk;

    fanpwm_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick_fast_i (tick_fast),
        .tick_slow_i (tick_slow),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .auto_duty_i (auto_duty),
        .pwm_o       (pwm)
    );

    initial begin
        tick_fast = 1'b0;
        tick_slow = 1'b0;
        forever begin
            @(negedge clk);
            tk = tk + 1;
            tick_fast = ((tk % fast_sp) == 0);
            tick_slow = ((tk % slow_sp) == 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(rdata == exp, req, "read-back", rdata, exp);
    endtask

    task automatic sync_rise();
        int n = 0;
        while (pwm !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
        while (pwm !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    endtask

    task automatic measure(input int exp_hi, input int exp_per, input string req);
        int hi = 0;
        int per = 0;
        bit prev = 1'b1;
        sync_rise();
        sync_rise();
        while (per < LIM) begin
            if (pwm && !prev && per > 0) break;
            if (pwm) hi++;
            per++;
            prev = pwm;
            @(negedge clk);
        end
        check(hi == exp_hi, req, "high cycles", hi, exp_hi);
        check(per == exp_per, req, "period cycles", per, exp_per);
    endtask

    task automatic count_level(input int n, input logic lvl, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm == lvl) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int lo;
        rd_check(2'd0, 8'h01, "R1");
        rd_check(2'd1, 8'hFF, "R1");
        rd_check(2'd2, 8'h00, "R1");
        count_level(600, 1'b0, lo);
        check(lo == 0, "R1", "low cycles after reset", lo, 0);
    endtask

    task automatic t_regmap();
        wr(2'd2, 8'hFF);
        rd_check(2'd2, 8'h30, "R2");
        wr(2'd2, 8'h00);
        rd_check(2'd2, 8'h00, "R2");
        wr(2'd0, 8'h85);
        rd_check(2'd0, 8'h85, "R2");
        rd_check(2'd3, 8'h00, "R2");
        wr(2'd0, 8'h00);
    endtask

    task automatic t_duty();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h40);
        measure(64, 256, "R3");
        wr(2'd1, 8'h01);
        measure(1, 256, "R3");
        wr(2'd1, 8'hFE);
        measure(254, 256, "R3");
    endtask

    task automatic t_div();
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h02);
        measure(384, 768, "R5");
        wr(2'd0, 8'h00);
    endtask

    task automatic t_extremes();
        int c;
        wr(2'd1, 8'h00);
        repeat (600) @(negedge clk);
        count_level(600, 1'b1, c);
        check(c == 0, "R4", "high cycles at duty 00h", c, 0);
        wr(2'd1, 8'hFF);
        repeat (600) @(negedge clk);
        count_level(600, 1'b0, c);
        check(c == 0, "R4", "low cycles at duty FFh", c, 0);
    endtask

    task automatic t_clksel();
        wr(2'd1, 8'h20);
        wr(2'd0, 8'h80);
        measure(128, 1024, "R6");
        wr(2'd0, 8'h00);
        measure(32, 256, "R6");
    endtask

    task automatic t_collision();
        int c;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h40);
        sync_rise();
        sync_rise();
        repeat (255) @(negedge clk);
        wr_en = 1'b1; addr = 2'd1; wdata = 8'hC0;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(rdata == 8'hC0, "R2", "read-back at collision", rdata, 8'hC0);
        @(negedge clk);
        count_level(255, 1'b1, c);
        c = c + 1;
        check(c == 64, "R7", "period after colliding write", c, 64);
        count_level(256, 1'b1, c);
        check(c == 192, "R7", "second period after write", c, 192);
    endtask

    task automatic t_auto();
        wr(2'd1, 8'h40);
        auto_duty = 8'h10;
        wr(2'd2, 8'h10);
        rd_check(2'd1, 8'h10, "R8");
        measure(16, 256, "R8");
        wr(2'd1, 8'h50);
        rd_check(2'd1, 8'h10, "R8");
        auto_duty = 8'h20;
        wr(2'd2, 8'h20);
        measure(32, 256, "R8");
        wr(2'd2, 8'h00);
        rd_check(2'd1, 8'h50, "R8");
        measure(80, 256, "R8");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00; auto_duty = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_duty();
        t_div();
        t_extremes();
        t_clksel();
        t_collision();
        t_auto();
        finish_run();
    end

endmodule